// File: doc/BRIEF.md
# LCD Sync Timing Generator

This block drives the timing side of a parallel LCD panel. It produces horizontal and vertical sync, a data-enable strobe, the active-area pixel coordinates and a one-cycle start-of-frame pulse. The panel geometry is supplied as four packed 32-bit timing words. Each word carries two 16-bit fields. A pixel-clock enable comes from a fractional divider. The divider can count either the system clock or a source running at twice that rate.

All logic runs on the system clock `clk`. Panel outputs advance only on cycles qualified by `pix_ce`. The `pclk` output rises or falls with the panel output change, depending on a polarity bit. Three enables, `pclk_en`, `sync_en` and `disp_en`, bring up the divider, the sync generator and the data-enable output one stage at a time. The geometry is taken into a shadow copy at the first pixel of every frame. A write to the timing words in the middle of a frame therefore takes effect at the next frame.

Top module: `lcd_sync_gen`

## Requirements
- R1: `tim_sync[15:0]` holds the hsync width minus one (pixels) and `tim_sync[31:16]` holds the vsync width minus one (lines).
- R2: `tim_vporch[15:0]` holds the vertical front porch minus one. `tim_vporch[31:16]` holds the vertical back porch as a plain line count, and zero is a legal value.
- R3: `tim_hporch[15:0]` holds the horizontal front porch minus one and `tim_hporch[31:16]` holds the horizontal back porch minus one.
- R4: `tim_active[15:0]` holds the active width minus one and `tim_active[31:16]` holds the active height minus one.
- R5: A line runs sync, back porch, active, front porch, and a frame runs the same four phases in lines. `de` is high only where both axes are active. `x` and `y` give the offset inside the active region of their axis and are 0 outside it.
- R6: `hs_low`=1 makes `hsync` active-low and `vs_low`=1 makes `vsync` active-low. When a bit is 0, its sync is active-high. Both bits act at once.
- R7: With `clk_dbl`=0, `pix_ce` pulses on average once every D system cycles, where D = `clk_div`. Any `clk_div` value of 0 or 1 is treated as 2.
- R8: With `clk_dbl`=1 the divider counts a source at twice the system rate, so that `pix_ce` pulses 2 times per D system cycles. With D=2 it pulses every cycle.
- R9: `pclk` equals the previous cycle's `pix_ce` XOR `clk_inv`. The panel outputs change only in cycles where that un-inverted level is high, so with `clk_inv`=0 they change with a rising `pclk` and with `clk_inv`=1 with a falling one.
- R10: `sof` pulses for one cycle when position (0,0) is output. The timing words are sampled at that point only, so a mid-frame write has no effect until the next frame.
- R11: While `sync_en` is low, `hsync` and `vsync` sit at their inactive level and `de`, `sof`, `x` and `y` are 0. The first pixel after `sync_en` rises is a frame start.
- R12: While `disp_en` is low, `de` stays 0 while the sync outputs keep running.
- R13: While `pclk_en` is low, `pix_ce` stays 0.
- R14: After reset, `pix_ce`, `de`, `sof`, `x` and `y` are 0, and `hsync`, `vsync` and `pclk` are at their inactive levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pclk_en | input | 1 | Divider stage enable |
| sync_en | input | 1 | Sync stage enable |
| disp_en | input | 1 | Data-enable stage enable |
| clk_div | input | DIV_W | Pixel clock divider (values below 2 act as 2) |
| clk_dbl | input | 1 | Count the doubled-rate source |
| clk_inv | input | 1 | Invert the pixel clock |
| hs_low | input | 1 | hsync active-low |
| vs_low | input | 1 | vsync active-low |
| tim_sync | input | 32 | Sync widths minus one (h low, v high) |
| tim_vporch | input | 32 | Vertical front porch minus one (low), back porch plain (high) |
| tim_hporch | input | 32 | Horizontal front porch minus one (low), back porch minus one (high) |
| tim_active | input | 32 | Active width minus one (low), height minus one (high) |
| pix_ce | output | 1 | Pixel clock enable, one system cycle wide |
| pclk | output | 1 | Pixel clock level for the panel |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| x | output | 16 | Active-area column |
| y | output | 16 | Active-area row |
| sof | output | 1 | Start-of-frame pulse |

## Verification
The assertions check on every cycle that the sync stage is idle while it is off and that `sof` lands on a sync-active origin. They also check that `de` never reports a column beyond the active width, that the shadow geometry changes only with `sof`, and that panel outputs move only on a high pixel-clock level. The exact field decoding, including the plain vertical back porch, cannot be seen by a local property. Neither can the average divider rate for each source, or the deferral of a mid-frame write. The bench sweeps complete frames of two small geometries, pixel by pixel, and counts divider pulses over fixed windows to cover these.

// File: rtl/lcd_timing_pkg.sv
package lcd_timing_pkg;

    localparam int FIELD_W = 16;
    localparam int WORD_W  = 2 * FIELD_W;
    localparam int CNT_W   = FIELD_W + 3;

    typedef logic [CNT_W-1:0]   cnt_t;
    typedef logic [FIELD_W-1:0] coord_t;
    typedef logic [WORD_W-1:0]  word_t;

    // Segment lengths, all in pixels or lines, offsets already removed
    typedef struct packed {
        cnt_t hs;
        cnt_t hb;
        cnt_t ha;
        cnt_t hf;
        cnt_t vs;
        cnt_t vb;
        cnt_t va;
        cnt_t vf;
    } geom_t;

    typedef struct packed {
        logic   sync;
        logic   act;
        coord_t pos;
    } axis_t;

    function automatic cnt_t field_len(input logic [FIELD_W-1:0] f, input logic add_one);
        return cnt_t'(f) + cnt_t'(add_one);
    endfunction

    function automatic geom_t unpack_geom(input word_t w_sync, input word_t w_vporch,
                                          input word_t w_hporch, input word_t w_act);
        geom_t g;
        g.hs = field_len(w_sync[FIELD_W-1:0], 1'b1);
        g.vs = field_len(w_sync[WORD_W-1:FIELD_W], 1'b1);
        g.vf = field_len(w_vporch[FIELD_W-1:0], 1'b1);
        g.vb = field_len(w_vporch[WORD_W-1:FIELD_W], 1'b0);
        g.hf = field_len(w_hporch[FIELD_W-1:0], 1'b1);
        g.hb = field_len(w_hporch[WORD_W-1:FIELD_W], 1'b1);
        g.ha = field_len(w_act[FIELD_W-1:0], 1'b1);
        g.va = field_len(w_act[WORD_W-1:FIELD_W], 1'b1);
        return g;
    endfunction

    // Position decode along one axis: sync, back porch, active, front porch
    function automatic axis_t decode_axis(input cnt_t c, input cnt_t s_len,
                                          input cnt_t b_len, input cnt_t a_len);
        axis_t r;
        cnt_t  lo;
        cnt_t  hi;
        lo     = s_len + b_len;
        hi     = lo + a_len;
        r.sync = (c < s_len);
        r.act  = (c >= lo) && (c < hi);
        r.pos  = r.act ? coord_t'(c - lo) : '0;
        return r;
    endfunction

endpackage

// File: rtl/lcd_pclk_div.sv
module lcd_pclk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             dbl,
    input  logic [DIV_W-1:0] div,
    output logic             ce,
    output logic             lvl
);
    localparam int ACC_W = DIV_W + 1;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] div_eff;
    logic [ACC_W-1:0] step;
    logic [ACC_W-1:0] sum;
    logic             wrap;

    always_comb begin
        div_eff = (div < DIV_W'(2)) ? ACC_W'(2) : {1'b0, div};
        step    = dbl ? ACC_W'(2) : ACC_W'(1);
        sum     = acc + step;
        wrap    = (sum >= div_eff);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            acc <= '0;
            ce  <= 1'b0;
        end else if (wrap) begin
            acc <= sum - div_eff;
            ce  <= 1'b1;
        end else begin
            acc <= sum;
            ce  <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) lvl <= 1'b0;
        else     lvl <= ce;
    end

    AST_CE_GATED: assert property (@(posedge clk) disable iff (rst)
        !en |=> !ce); // R13

endmodule

// File: rtl/lcd_geom_shadow.sv
module lcd_geom_shadow
    import lcd_timing_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  word_t w_sync,
    input  word_t w_vporch,
    input  word_t w_hporch,
    input  word_t w_act,
    output geom_t g_live,
    output geom_t g_cur
);
    assign g_live = unpack_geom(w_sync, w_vporch, w_hporch, w_act);

    always_ff @(posedge clk) begin
        if (rst)       g_cur <= '0;
        else if (load) g_cur <= g_live;
    end

endmodule

// File: rtl/lcd_scan_core.sv
module lcd_scan_core
    import lcd_timing_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ce,
    input  logic   sync_en,
    input  logic   disp_en,
    input  geom_t  g_live,
    input  geom_t  g_cur,
    output logic   load,
    output logic   hs_act,
    output logic   vs_act,
    output logic   de,
    output coord_t x,
    output coord_t y,
    output logic   sof
);
    logic  running;
    cnt_t  hcnt;
    cnt_t  vcnt;
    cnt_t  h_tot;
    cnt_t  v_tot;
    logic  h_last;
    logic  v_last;
    logic  start;
    geom_t g_use;
    cnt_t  h_n;
    cnt_t  v_n;
    axis_t ax_h;
    axis_t ax_v;

    always_comb begin
        h_tot  = g_cur.hs + g_cur.hb + g_cur.ha + g_cur.hf;
        v_tot  = g_cur.vs + g_cur.vb + g_cur.va + g_cur.vf;
        h_last = (hcnt == h_tot - cnt_t'(1));
        v_last = (vcnt == v_tot - cnt_t'(1));
        start  = ce && sync_en && (!running || (h_last && v_last));
        g_use  = start ? g_live : g_cur;
        if (start) begin
            h_n = '0;
            v_n = '0;
        end else if (h_last) begin
            h_n = '0;
            v_n = vcnt + cnt_t'(1);
        end else begin
            h_n = hcnt + cnt_t'(1);
            v_n = vcnt;
        end
        ax_h = decode_axis(h_n, g_use.hs, g_use.hb, g_use.ha);
        ax_v = decode_axis(v_n, g_use.vs, g_use.vb, g_use.va);
    end

    assign load = start;

    always_ff @(posedge clk) begin
        if (rst || !sync_en) begin
            running <= 1'b0;
            hcnt    <= '0;
            vcnt    <= '0;
            hs_act  <= 1'b0;
            vs_act  <= 1'b0;
            de      <= 1'b0;
            x       <= '0;
            y       <= '0;
            sof     <= 1'b0;
        end else begin
            sof <= 1'b0;
            if (ce) begin
                running <= 1'b1;
                hcnt    <= h_n;
                vcnt    <= v_n;
                hs_act  <= ax_h.sync;
                vs_act  <= ax_v.sync;
                de      <= ax_h.act && ax_v.act && disp_en;
                x       <= ax_h.pos;
                y       <= ax_v.pos;
                sof     <= start;
            end
        end
    end

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !sync_en |=> (!hs_act && !vs_act && !de && !sof && x == '0 && y == '0)); // R11
    AST_DE_X_RANGE: assert property (@(posedge clk) disable iff (rst)
        de |-> (cnt_t'(x) < g_cur.ha && cnt_t'(y) < g_cur.va)); // R5
    AST_SOF_AT_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        sof |-> (hs_act && vs_act && !de)); // R10
    AST_SHADOW_AT_SOF: assert property (@(posedge clk) disable iff (rst)
        !$stable(g_cur) |-> sof); // R10

endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
    import lcd_timing_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pclk_en,
    input  logic               sync_en,
    input  logic               disp_en,
    input  logic [DIV_W-1:0]   clk_div,
    input  logic               clk_dbl,
    input  logic               clk_inv,
    input  logic               hs_low,
    input  logic               vs_low,
    input  logic [WORD_W-1:0]  tim_sync,
    input  logic [WORD_W-1:0]  tim_vporch,
    input  logic [WORD_W-1:0]  tim_hporch,
    input  logic [WORD_W-1:0]  tim_active,
    output logic               pix_ce,
    output logic               pclk,
    output logic               hsync,
    output logic               vsync,
    output logic               de,
    output logic [FIELD_W-1:0] x,
    output logic [FIELD_W-1:0] y,
    output logic               sof
);
    logic  ce_w;
    logic  lvl_w;
    logic  load_w;
    logic  hs_act_w;
    logic  vs_act_w;
    geom_t g_live_w;
    geom_t g_cur_w;

    lcd_pclk_div #(.DIV_W(DIV_W)) i_div (
        .clk (clk),
        .rst (rst),
        .en  (pclk_en),
        .dbl (clk_dbl),
        .div (clk_div),
        .ce  (ce_w),
        .lvl (lvl_w)
    );

    lcd_geom_shadow i_shadow (
        .clk      (clk),
        .rst      (rst),
        .load     (load_w),
        .w_sync   (tim_sync),
        .w_vporch (tim_vporch),
        .w_hporch (tim_hporch),
        .w_act    (tim_active),
        .g_live   (g_live_w),
        .g_cur    (g_cur_w)
    );

    lcd_scan_core i_core (
        .clk     (clk),
        .rst     (rst),
        .ce      (ce_w),
        .sync_en (sync_en),
        .disp_en (disp_en),
        .g_live  (g_live_w),
        .g_cur   (g_cur_w),
        .load    (load_w),
        .hs_act  (hs_act_w),
        .vs_act  (vs_act_w),
        .de      (de),
        .x       (x),
        .y       (y),
        .sof     (sof)
    );

    assign pix_ce = ce_w;
    assign pclk   = lvl_w ^ clk_inv;
    assign hsync  = hs_act_w ^ hs_low;
    assign vsync  = vs_act_w ^ vs_low;

    AST_OUT_ON_PCLK: assert property (@(posedge clk) disable iff (rst)
        ($past(sync_en) && !$stable(hs_act_w)) |-> lvl_w); // R9

endmodule

// File: tb/test_lcd_sync_gen.sv
`timescale 1ns/1ps
module test_lcd_sync_gen;

    typedef struct {
        int hs; int hb; int ha; int hf;
        int vs; int vb; int va; int vf;
    } tg_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pclk_en = 1'b0, sync_en = 1'b0, disp_en = 1'b0;
    logic [7:0]  clk_div = 8'd2;
    logic        clk_dbl = 1'b0, clk_inv = 1'b0, hs_low = 1'b0, vs_low = 1'b0;
    logic [31:0] tim_sync = '0, tim_vporch = '0, tim_hporch = '0, tim_active = '0;
    logic        pix_ce, pclk, hsync, vsync, de, sof;
    logic [15:0] x, y;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    lcd_sync_gen #(.DIV_W(8)) i_lcd_sync_gen (
        .clk(clk), .rst(rst), .pclk_en(pclk_en), .sync_en(sync_en), .disp_en(disp_en),
        .clk_div(clk_div), .clk_dbl(clk_dbl), .clk_inv(clk_inv),
        .hs_low(hs_low), .vs_low(vs_low),
        .tim_sync(tim_sync), .tim_vporch(tim_vporch), .tim_hporch(tim_hporch),
        .tim_active(tim_active),
        .pix_ce(pix_ce), .pclk(pclk), .hsync(hsync), .vsync(vsync), .de(de),
        .x(x), .y(y), .sof(sof)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive_geom(input tg_t g);
        tim_sync   = {16'(g.vs - 1), 16'(g.hs - 1)};
        tim_vporch = {16'(g.vb),     16'(g.vf - 1)};
        tim_hporch = {16'(g.hb - 1), 16'(g.hf - 1)};
        tim_active = {16'(g.va - 1), 16'(g.ha - 1)};
    endtask

    task automatic wait_sof();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (sof) return;
        end
        chk("R10", "sof timeout", 32'd0, 32'd1);
    endtask

    // Called at the negedge showing pixel 0; pix_ce is high every cycle.
    task automatic check_frame(input tg_t g, input bit de_on, input string tag,
                               input bit mid, input tg_t g2);
        int ht = g.hs + g.hb + g.ha + g.hf;
        int vt = g.vs + g.vb + g.va + g.vf;
        for (int n = 0; n < ht * vt; n++) begin
            int  h = n % ht;
            int  v = n / ht;
            int  hl = g.hs + g.hb;
            int  vl = g.vs + g.vb;
            bit  ha = (h >= hl) && (h < hl + g.ha);
            bit  va = (v >= vl) && (v < vl + g.va);
            logic [3:0] e_flags;
            logic [31:0] e_xy;
            e_flags = {1'((h < g.hs) ^ hs_low), 1'((v < g.vs) ^ vs_low),
                       1'(ha && va && de_on), 1'(n == 0)};
            e_xy = {16'(va ? v - vl : 0), 16'(ha ? h - hl : 0)};
            chk(tag, "hsync/vsync/de/sof", {28'd0, hsync, vsync, de, sof}, {28'd0, e_flags});
            chk("R5", "y/x", {y, x}, e_xy);
            if (mid && n == (ht * vt) / 2) drive_geom(g2);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk("WDOG", "watchdog expired", 32'd0, 32'd1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    task automatic count_ce(input int d, input bit dbl, input int win, input int exp,
                            input string req);
        int cnt = 0;
        clk_div = 8'(d);
        clk_dbl = dbl;
        repeat (12) @(negedge clk);
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (pix_ce) cnt++;
        end
        chk(req, $sformatf("pix_ce count div=%0d dbl=%0d", d, dbl), cnt, exp);
    endtask

    initial begin
        tg_t ga, gb;
        logic prev_ce, prev_hs;
        ga = '{hs:2, hb:3, ha:4, hf:2, vs:1, vb:0, va:3, vf:1};
        gb = '{hs:1, hb:2, ha:3, hf:3, vs:2, vb:2, va:2, vf:2};

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R14 reset state
        chk("R14", "reset outputs", {24'd0, pix_ce, pclk, hsync, vsync, de, sof, |x, |y}, 32'd0);

        // R7 / R8 / R13 divider rates
        pclk_en = 1'b1;
        count_ce(5, 1'b0, 50, 10, "R7");
        count_ce(0, 1'b0, 50, 25, "R7");
        count_ce(1, 1'b0, 40, 20, "R7");
        count_ce(3, 1'b1, 60, 40, "R8");
        count_ce(2, 1'b1, 30, 30, "R8");
        count_ce(4, 1'b1, 40, 20, "R8");
        pclk_en = 1'b0;
        count_ce(3, 1'b0, 20, 0, "R13");
        pclk_en = 1'b1;

        // R9 pixel clock level and output edge relation
        drive_geom(ga);
        clk_div = 8'd3;
        clk_dbl = 1'b0;
        sync_en = 1'b1;
        disp_en = 1'b1;
        for (int inv = 0; inv < 2; inv++) begin
            clk_inv = 1'(inv);
            @(negedge clk);
            prev_ce = pix_ce;
            prev_hs = hsync;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                chk("R9", "pclk level", {31'd0, pclk}, {31'd0, 1'(prev_ce ^ inv)});
                if (hsync !== prev_hs)
                    chk("R9", "hsync moved off pclk edge", {31'd0, 1'(pclk ^ inv)}, 32'd1);
                prev_ce = pix_ce;
                prev_hs = hsync;
            end
        end
        clk_inv = 1'b0;

        // Frame sweeps with a pixel every cycle
        sync_en = 1'b0;
        clk_div = 8'd2;
        clk_dbl = 1'b1;
        @(negedge clk);
        sync_en = 1'b1;
        wait_sof();
        check_frame(ga, 1'b1, "R1 R2 R3 R4 R10", 1'b0, ga);
        check_frame(ga, 1'b1, "R1 R2 R3 R4 R10", 1'b0, ga);

        sync_en = 1'b0;
        drive_geom(gb);
        hs_low = 1'b1;
        vs_low = 1'b1;
        @(negedge clk);
        sync_en = 1'b1;
        wait_sof();
        check_frame(gb, 1'b1, "R1 R2 R3 R4 R6", 1'b0, gb);

        // R11 idle while sync stage is off
        sync_en = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            chk("R11", "idle outputs", {26'd0, hsync, vsync, de, sof, |x, |y}, 32'b110000);
            @(negedge clk);
        end
        hs_low = 1'b0;
        #1;
        chk("R6", "hsync polarity live", {31'd0, hsync}, 32'd0);
        vs_low = 1'b0;

        // R12 data enable gated off
        drive_geom(ga);
        disp_en = 1'b0;
        @(negedge clk);
        sync_en = 1'b1;
        wait_sof();
        check_frame(ga, 1'b0, "R12", 1'b0, ga);

        // R10 mid-frame write deferred to the next frame
        disp_en = 1'b1;
        wait_sof();
        check_frame(ga, 1'b1, "R10", 1'b1, gb);
        check_frame(gb, 1'b1, "R10", 1'b0, gb);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule